// File: doc/BRIEF.md
# Serial Dot-Correction Loader

This block receives per-channel current-correction words for a sixteen-channel output driver, one bit at a time, and presents them as sixteen six-bit correction values. Serial bits arrive on a valid/ready bit stream in the system clock domain. A bit is accepted on a rising clock edge when `in_valid` and `in_ready` are both high. The bit that the shift register pushes out appears on `sout`. The next device in a daisy chain takes that pin as its own serial input. During the next frame it replays the previous frame, first bit first.

A level-sensitive strobe, `latch_en`, moves the whole 96-bit shift register into the correction register. While the strobe is high and correction mode is selected, `dc_out` follows the shift register in the same cycle. When the strobe falls, the value it showed last is held. Back-pressure: `in_ready` is low whenever correction mode is off or the strobe is high. While `in_ready` is low, bits offered on the stream are dropped. A sender must hold `in_valid` and `in_bit` until `in_ready` returns.

Top module: `dcl_loader`

## Requirements
- R1: While `rst_n` is low, and afterwards until bits are accepted, the shift register and the correction register are zero, so `dc_out` and `sout` read zero.
- R2: `in_ready` is high exactly when `mode_dc` is high and `latch_en` is low. A bit is shifted in only on a clock edge where `in_valid` and `in_ready` are both high.
- R3: Bits are packed MSB first with channel 15 first. Serial bit k of a 96-bit frame (k=0 first) lands in channel 15-(k/6), at bit position 5-(k mod 6). Channel n appears on `dc_out[6n+5:6n]`.
- R4: `sout` shows the oldest stored bit. Before the k-th accepted bit of a new frame it shows bit k of the previous frame. After 96 accepted bits it shows bit 0 of the new frame.
- R5: While `mode_dc` and `latch_en` are both high, `dc_out` equals the unpacked shift register in the same cycle, with no clock edge in between.
- R6: Once `latch_en` is low, `dc_out` keeps the last value loaded, however many bits are then shifted.
- R7: While `mode_dc` is low, `latch_en` and the bit stream have no effect: `dc_out` and `sout` do not change.
- R8: A bit offered while `latch_en` is high is not accepted, and `sout` stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_dc | input | 1 | Selects correction-entry mode |
| in_valid | input | 1 | Serial bit is offered |
| in_ready | output | 1 | Serial bit can be accepted |
| in_bit | input | 1 | Serial data bit |
| sout | output | 1 | Oldest shift-register bit, for daisy chaining |
| latch_en | input | 1 | Level-transparent load strobe |
| dc_out | output | 96 | Sixteen 6-bit correction values, channel n at bits 6n+5..6n |

## Verification
The bench sends 66 frames of channel values computed in the bench, including frames where every channel is 0 or 63. It checks every bit on `sout` against the previous frame, so a design with the wrong shift direction or an off-by-one in the chain output fails on the first bit. It reads `dc_out` one nanosecond after the strobe rises, which catches a design that loads on an edge instead of transparently. It reads `dc_out` again after a full frame is shifted with the strobe low, which catches a design that keeps the correction register open. With the mode input low, and with the strobe high, it offers bits and raises the strobe. A design that does not gate these leaks the new data onto the outputs or moves `sout`.

// File: rtl/dcl_pkg.sv
package dcl_pkg;
  parameter int unsigned DCL_CHANNELS = 16;
  parameter int unsigned DCL_WIDTH    = 6;
endpackage

// File: rtl/dcl_shift.sv
module dcl_shift #(
  parameter int unsigned LEN = 96
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           take,
  input  logic           bit_in,
  output logic [LEN-1:0] shreg,
  output logic           bit_out
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg <= '0;
    else if (take) shreg <= {shreg[LEN-2:0], bit_in};
  end

  assign bit_out = shreg[LEN-1];

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(shreg)); // R2
  AST_BIT_ENTERS: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> shreg[0] == $past(bit_in)); // R3
  AST_OUT_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> bit_out == $past(shreg[LEN-2])); // R4
endmodule

// File: rtl/dcl_hold.sv
module dcl_hold #(
  parameter int unsigned LEN = 96
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           open,
  input  logic [LEN-1:0] src,
  output logic [LEN-1:0] view
);
  logic [LEN-1:0] held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_q <= '0;
    else if (open) held_q <= src;
  end

  // transparent while open, otherwise the last captured value
  assign view = open ? src : held_q;

  AST_HOLD_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    !open |=> $stable(held_q)); // R6
  AST_CAPTURE_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    open |=> held_q == $past(src)); // R5
endmodule

// File: rtl/dcl_unpack.sv
module dcl_unpack #(
  parameter int unsigned CH = 16,
  parameter int unsigned W  = 6
) (
  input  logic [CH*W-1:0] word,
  output logic [CH*W-1:0] chan
);
  // first serial bit sits at the top of the word: channel n is slice n
  for (genvar n = 0; n < CH; n++) begin : g_ch
    for (genvar b = 0; b < W; b++) begin : g_bit
      assign chan[n*W + b] = word[n*W + b];
    end
  end
endmodule

// File: rtl/dcl_loader.sv
module dcl_loader
  import dcl_pkg::*;
#(
  parameter int unsigned CHANNELS = DCL_CHANNELS,
  parameter int unsigned WIDTH    = DCL_WIDTH
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      mode_dc,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic                      in_bit,
  output logic                      sout,
  input  logic                      latch_en,
  output logic [CHANNELS*WIDTH-1:0] dc_out
);
  localparam int unsigned FRAME = CHANNELS * WIDTH;

  logic             take;
  logic             open;
  logic [FRAME-1:0] shreg;
  logic [FRAME-1:0] view;

  assign in_ready = mode_dc && !latch_en;
  assign take     = in_valid && in_ready;
  assign open     = mode_dc && latch_en;

  dcl_shift #(.LEN(FRAME)) u_shift (
    .clk(clk), .rst_n(rst_n), .take(take), .bit_in(in_bit),
    .shreg(shreg), .bit_out(sout)
  );

  dcl_hold #(.LEN(FRAME)) u_hold (
    .clk(clk), .rst_n(rst_n), .open(open), .src(shreg), .view(view)
  );

  dcl_unpack #(.CH(CHANNELS), .W(WIDTH)) u_unpack (
    .word(view), .chan(dc_out)
  );

  AST_MODE_OFF_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_dc && $past(!mode_dc)) |-> $stable(sout)); // R7
  AST_NO_TAKE_IN_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $past(latch_en) |-> $stable(sout)); // R8
  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |-> (dc_out == '0 && !sout)); // R1
endmodule

// File: tb/test_dcl_loader.sv
module test_dcl_loader;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        mode_dc = 0;
  logic        in_valid = 0;
  logic        in_ready;
  logic        in_bit = 0;
  logic        sout;
  logic        latch_en = 0;
  logic [95:0] dc_out;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dcl_loader i_dcl_loader (
    .clk(clk), .rst_n(rst_n), .mode_dc(mode_dc), .in_valid(in_valid),
    .in_ready(in_ready), .in_bit(in_bit), .sout(sout),
    .latch_en(latch_en), .dc_out(dc_out)
  );

  function automatic logic [95:0] mk(int base, int step);
    logic [95:0] f;
    for (int n = 0; n < 16; n++) f[n*6 +: 6] = 6'((base + n*step) & 63);
    return f;
  endfunction

  task automatic chk(bit ok, string req, logic [95:0] act, logic [95:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // serial bit k of the frame is word index 95-k
  task automatic send(logic [95:0] fr, logic [95:0] prev);
    for (int j = 95; j >= 0; j--) begin
      @(negedge clk);
      chk(sout === prev[j], "R4 sout echo", 96'(sout), 96'(prev[j]));
      in_valid = 1; in_bit = fr[j];
    end
    @(negedge clk);
    in_valid = 0;
    chk(sout === fr[95], "R4 sout after frame", 96'(sout), 96'(fr[95]));
  endtask

  task automatic strobe(logic [95:0] exp);
    @(negedge clk); latch_en = 1; #1;
    chk(dc_out === exp, "R5 R3 transparent", dc_out, exp);
    chk(in_ready === 0, "R2 ready low in strobe", 96'(in_ready), 96'(0));
    @(negedge clk); latch_en = 0; #1;
    chk(dc_out === exp, "R6 hold after strobe", dc_out, exp);
  endtask

  initial begin
    logic [95:0] a, b, prev, cur;
    logic s0;
    #3;
    chk(dc_out === '0, "R1 reset dc", dc_out, '0);
    chk(sout === 0, "R1 reset sout", 96'(sout), 96'(0));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(in_ready === 0, "R2 ready low mode off", 96'(in_ready), 96'(0));
    mode_dc = 1; #1;
    chk(in_ready === 1, "R2 ready high", 96'(in_ready), 96'(1));

    a = mk(1, 7);
    b = mk(63, 61);
    send(a, '0);
    #1;
    chk(dc_out === '0, "R6 no load without strobe", dc_out, '0);
    strobe(a);
    // channel 15 holds the first six serial bits
    chk(dc_out[95:90] === a[95:90], "R3 channel 15 slot", 96'(dc_out[95:90]), 96'(a[95:90]));

    // R8: offer bits during the strobe
    @(negedge clk); latch_en = 1; s0 = sout;
    in_valid = 1; in_bit = ~sout;
    repeat (3) @(negedge clk);
    chk(sout === s0, "R8 no shift in strobe", 96'(sout), 96'(s0));
    in_valid = 0; latch_en = 0;

    send(b, a);
    #1;
    chk(dc_out === a, "R6 hold while shifting", dc_out, a);

    // R7: mode off ignores strobe and stream
    @(negedge clk); mode_dc = 0; s0 = sout;
    latch_en = 1; in_valid = 1; in_bit = ~sout; #1;
    chk(dc_out === a, "R7 strobe ignored", dc_out, a);
    chk(in_ready === 0, "R7 ready low", 96'(in_ready), 96'(0));
    repeat (4) @(negedge clk);
    chk(sout === s0, "R7 stream ignored", 96'(sout), 96'(s0));
    chk(dc_out === a, "R7 dc unchanged", dc_out, a);
    latch_en = 0; in_valid = 0;
    @(negedge clk); mode_dc = 1;
    strobe(b);

    // sweep: every base value, including all-zero and all-63 frames
    prev = b;
    for (int v = 0; v < 64; v++) begin
      cur = (v == 0) ? '0 : (v == 63) ? {96{1'b1}} : mk(v, 1 + (v % 5));
      send(cur, prev);
      strobe(cur);
      prev = cur;
    end

    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule